// File: doc/BRIEF.md
# Allocation Range Initialization Tracker

This block sits beside a data cache and tells the miss path whether a store is about to write a cache block of a heap allocation that has never been written before. When the answer is yes, the cache can install the block directly without fetching stale contents from memory. Software registers each new allocation by presenting its starting byte address and its size in bytes. The tracker keeps a fully associative table of the most recent allocations, with first-in-first-out replacement.

Each entry keeps the block range of its allocation. It also keeps one lower/upper limit pair per interleave slot, and these limits shrink as the allocation is written. Blocks are 64 bytes. A block belongs to the slot given by its block index modulo the slot count, with an interleave granularity of one block. For every store the block is looked up, and the answer arrives one cycle later. The store also narrows the limits of the slot it landed in. In forward mode the lower limit always moves. In bidirectional mode the lower limit or the upper limit moves, depending on where the store falls in the remaining window.

Top module: `art_tracker`

## Requirements
- R1: After reset the table is empty, `res_valid_o` and `res_init_o` are low, and a store reports not initializing.
- R2: A registration with nonzero size sets the entry's range, and every slot's limits, to the blocks from `alloc_base_i>>6` to `(alloc_base_i+alloc_size_i-1)>>6`. A registration with size 0 is ignored.
- R3: `res_valid_o` is high in exactly the cycle after each cycle with `st_valid_i` high. `res_init_o` is high only together with it.
- R4: A store whose block lies in no registered range reports not initializing and changes no state.
- R5: The slot of block b is b mod 2, and each slot's limits are tracked independently. A store is initializing only if its block lies within the current limits of its slot.
- R6: With `bidir_i`=0, an initializing store to block b sets its slot's lower limit to b+1. Later stores in that slot below the new limit report not initializing.
- R7: With `bidir_i`=1, an initializing store to block b is tested against the slot's lower limit lo and upper limit hi. If (b-lo) > (hi-b), the upper limit becomes b-1. Otherwise the lower limit becomes b+1.
- R8: An initializing store to the block equal to the slot's upper limit, through the lower-limit update, exhausts the slot. An exhausted slot never reports initializing again, including for other byte offsets in the same block.
- R9: The table holds 64 allocations. Registration number 65 replaces the oldest entry, and the other entries stay in place.
- R10: When several ranges contain the store's block, only the most recently registered one decides the result and gets updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bidir_i | input | 1 | Sweep mode for stores: 0 forward, 1 bidirectional |
| alloc_valid_i | input | 1 | Register an allocation this cycle |
| alloc_base_i | input | 32 | Allocation start byte address |
| alloc_size_i | input | 32 | Allocation size in bytes |
| st_valid_i | input | 1 | Store lookup this cycle |
| st_addr_i | input | 32 | Store byte address |
| res_valid_o | output | 1 | Lookup result valid, one cycle after the store |
| res_init_o | output | 1 | Store writes a never-written block of a tracked allocation |

## Verification
Several properties are checked on every cycle by assertions: the one-cycle spacing between a store and its result, and that a flag is never raised without a result. They also check that at most one entry is updated per store, that a store hitting no range never flags, and that slot limits only ever narrow between registrations, with exhausted slots staying exhausted. Only the bench scenarios can show whether the limits narrow to the right block. The same holds for the upper-half test in bidirectional mode, the slot selection, the choice of the newest entry among overlapping ranges, and which entry FIFO replacement evicts.

// File: rtl/art_pkg.sv
`timescale 1ns/1ps
package art_pkg;
  typedef enum logic {
    SWEEP_FWD   = 1'b0,
    SWEEP_BIDIR = 1'b1
  } sweep_mode_e;
endpackage

// File: rtl/art_sweep.sv
`timescale 1ns/1ps
// Next limits of one interleave slot after an initializing store to blk_i.
module art_sweep
  import art_pkg::*;
#(
  parameter int BW = 26
) (
  input  logic [BW-1:0] base_i,
  input  logic [BW-1:0] bound_i,
  input  logic [BW-1:0] blk_i,
  input  sweep_mode_e   mode_i,
  output logic [BW-1:0] base_o,
  output logic [BW-1:0] bound_o,
  output logic          done_o
);
  logic [BW-1:0] lo_gap, hi_gap;
  logic          cut_top;

  always_comb begin
    lo_gap  = blk_i - base_i;
    hi_gap  = bound_i - blk_i;
    cut_top = (mode_i == SWEEP_BIDIR) && (lo_gap > hi_gap);
    if (cut_top) begin
      base_o  = base_i;
      bound_o = blk_i - BW'(1);
      done_o  = 1'b0;
    end else begin
      base_o  = blk_i + BW'(1);
      bound_o = bound_i;
      done_o  = (blk_i == bound_i);
    end
  end
endmodule

// File: rtl/art_entry.sv
`timescale 1ns/1ps
module art_entry
  import art_pkg::*;
#(
  parameter int BW      = 26,
  parameter int NSLOT   = 2,
  parameter int IL_LOG2 = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] load_start_i,
  input  logic [BW-1:0] load_end_i,
  input  logic [BW-1:0] blk_i,
  input  sweep_mode_e   mode_i,
  input  logic          upd_i,
  output logic          hit_o,
  output logic          init_o
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic          vld_q;
  logic [BW-1:0] start_q, end_q;
  logic [BW-1:0] base_q  [NSLOT];
  logic [BW-1:0] bound_q [NSLOT];
  logic [NSLOT-1:0] done_q;

  logic [BW-1:0]     il_idx;
  logic [SLOT_W-1:0] slot;
  logic [BW-1:0]     nx_base, nx_bound;
  logic              nx_done;

  always_comb begin
    il_idx = blk_i >> IL_LOG2;
    slot   = SLOT_W'(il_idx % BW'(NSLOT));
    hit_o  = vld_q && (blk_i >= start_q) && (blk_i <= end_q);
    init_o = hit_o && !done_q[slot] &&
             (blk_i >= base_q[slot]) && (blk_i <= bound_q[slot]);
  end

  art_sweep #(.BW(BW)) i_sweep (
    .base_i  (base_q[slot]),
    .bound_i (bound_q[slot]),
    .blk_i   (blk_i),
    .mode_i  (mode_i),
    .base_o  (nx_base),
    .bound_o (nx_bound),
    .done_o  (nx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
      done_q  <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
      end
    end else if (load_i) begin
      vld_q   <= 1'b1;
      start_q <= load_start_i;
      end_q   <= load_end_i;
      done_q  <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        base_q[s]  <= load_start_i;
        bound_q[s] <= load_end_i;
      end
    end else if (upd_i && init_o) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot == SLOT_W'(s)) begin
          base_q[s]  <= nx_base;
          bound_q[s] <= nx_bound;
          done_q[s]  <= nx_done;
        end
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    AST_BASE_NEVER_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> base_q[s] >= $past(base_q[s])); // R6
    AST_BOUND_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> bound_q[s] <= $past(bound_q[s])); // R7
    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q[s] && !load_i) |=> done_q[s]); // R8
  end
endmodule

// File: rtl/art_tracker.sv
`timescale 1ns/1ps
// ENTRIES must be a power of two (age scan relies on pointer wrap).
module art_tracker
  import art_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 6,
  parameter int ENTRIES  = 64,
  parameter int NSLOT    = 2,
  parameter int IL_LOG2  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bidir_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  input  logic [ADDR_W-1:0] alloc_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              res_valid_o,
  output logic              res_init_o
);
  localparam int BW    = ADDR_W - BLK_LOG2;
  localparam int PTR_W = $clog2(ENTRIES);

  logic [PTR_W-1:0]   wr_ptr_q;
  logic               alloc_ok;
  logic [ADDR_W-1:0]  last_addr;
  logic [BW-1:0]      start_blk, end_blk, st_blk;
  logic [ENTRIES-1:0] load, hit, init, upd;
  logic               found;
  logic [PTR_W-1:0]   sel, age_idx;
  sweep_mode_e        mode;
  logic               res_valid_q, res_init_q;
  logic               unused_low;

  assign alloc_ok   = alloc_valid_i && (alloc_size_i != '0);
  assign last_addr  = alloc_base_i + alloc_size_i - ADDR_W'(1);
  assign start_blk  = alloc_base_i[ADDR_W-1:BLK_LOG2];
  assign end_blk    = last_addr[ADDR_W-1:BLK_LOG2];
  assign st_blk     = st_addr_i[ADDR_W-1:BLK_LOG2];
  assign mode       = sweep_mode_e'(bidir_i);
  assign unused_low = ^{alloc_base_i[BLK_LOG2-1:0], last_addr[BLK_LOG2-1:0],
                        st_addr_i[BLK_LOG2-1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign load[e] = alloc_ok && (wr_ptr_q == PTR_W'(e));
    assign upd[e]  = st_valid_i && found && (sel == PTR_W'(e));
    art_entry #(.BW(BW), .NSLOT(NSLOT), .IL_LOG2(IL_LOG2)) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load[e]),
      .load_start_i (start_blk),
      .load_end_i   (end_blk),
      .blk_i        (st_blk),
      .mode_i       (mode),
      .upd_i        (upd[e]),
      .hit_o        (hit[e]),
      .init_o       (init[e])
    );
  end

  // Newest matching entry wins: scan from the slot written last.
  always_comb begin
    found   = 1'b0;
    sel     = '0;
    age_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      age_idx = wr_ptr_q - PTR_W'(1) - PTR_W'(k);
      if (!found && hit[age_idx]) begin
        found = 1'b1;
        sel   = age_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      res_valid_q <= 1'b0;
      res_init_q  <= 1'b0;
    end else begin
      if (alloc_ok) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      res_valid_q <= st_valid_i;
      res_init_q  <= st_valid_i && found && init[sel];
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_init_o  = res_init_q;

  AST_RESULT_FOLLOWS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> res_valid_o); // R3
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |=> !res_valid_o); // R3
  AST_FLAG_NEEDS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_init_o |-> res_valid_o); // R3
  AST_SINGLE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd)); // R10
  AST_MISS_NOT_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && hit == '0) |=> !res_init_o); // R4
endmodule

// File: tb/test_art_tracker.sv
`timescale 1ns/1ps
module test_art_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bidir = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [31:0] alloc_base = '0, alloc_size = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        res_valid, res_init;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct { logic init; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  art_tracker i_art_tracker (
    .clk_i(clk), .rst_ni(rst_n), .bidir_i(bidir),
    .alloc_valid_i(alloc_valid), .alloc_base_i(alloc_base), .alloc_size_i(alloc_size),
    .st_valid_i(st_valid), .st_addr_i(st_addr),
    .res_valid_o(res_valid), .res_init_o(res_init)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic alloc(logic [31:0] base, logic [31:0] size);
    @(negedge clk);
    st_valid = 1'b0;
    alloc_valid = 1'b1; alloc_base = base; alloc_size = size;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  // Driver: one store per call; consecutive calls are back to back.
  task automatic store(logic [31:0] addr, logic exp, string tag);
    exp_t it;
    @(negedge clk);
    st_valid = 1'b1; st_addr = addr;
    it.init = exp; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    st_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected result", 32'(res_valid), 32'h0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check(res_init === it.init, it.tag, 32'(res_init), 32'(it.init));
      end
    end
  end

  initial begin
    #600000;
    check(1'b0, "watchdog", 32'h0, 32'h1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'h0);
    check(res_init === 1'b0, "R1 res_init after reset", 32'(res_init), 32'h0);
    store(32'h1000, 1'b0, "R1 empty table");
    idle(2);
    check(exp_q.size() == 0, "R3 result arrived", 32'(exp_q.size()), 32'h0);

    // Forward sweeping over blocks 0x40..0x45 (slot = block[0])
    bidir = 1'b0;
    alloc(32'h1000, 32'd384);
    store(32'h1000, 1'b1, "R6 first write blk40");
    store(32'h1000, 1'b0, "R6 rewrite blk40");
    store(32'h1080, 1'b1, "R6 write blk42");
    store(32'h1040, 1'b1, "R5 slot1 blk41 independent");
    store(32'h1080, 1'b0, "R6 rewrite blk42");
    store(32'h1100, 1'b1, "R6 write blk44");
    store(32'h1140, 1'b1, "R5 slot1 blk45");
    store(32'h10C0, 1'b0, "R8 slot1 exhausted blk43");
    store(32'h2000, 1'b0, "R4 no range");
    store(32'h1180, 1'b0, "R4 one past end");
    idle(1);
    check(res_valid === 1'b0, "R3 idle no result", 32'(res_valid), 32'h0);

    // Size zero ignored
    alloc(32'h3000, 32'd0);
    store(32'h3000, 1'b0, "R2 size zero ignored");

    // Bidirectional over blocks 0x100..0x10F, slot0 even blocks
    idle(0);
    bidir = 1'b1;
    alloc(32'h4000, 32'd1024);
    store(32'h4380, 1'b1, "R7 blk10E upper");
    store(32'h4300, 1'b1, "R7 blk10C upper");
    store(32'h4380, 1'b0, "R7 blk10E above bound");
    store(32'h4000, 1'b1, "R7 blk100 lower");
    store(32'h4000, 1'b0, "R7 blk100 below base");
    store(32'h4100, 1'b1, "R7 blk104 lower");
    store(32'h4080, 1'b0, "R7 blk102 below base");
    store(32'h4280, 1'b1, "R7 blk10A upper");
    store(32'h4180, 1'b1, "R7 blk106 lower");
    store(32'h4200, 1'b1, "R7 blk108 tie lower");
    store(32'h4200, 1'b0, "R8 slot0 exhausted blk108");

    // Single-block allocation exhausts on one write
    alloc(32'h8000, 32'd64);
    store(32'h8000, 1'b1, "R8 single block first");
    store(32'h803F, 1'b0, "R8 same block other offset");
    // End block derived from byte range
    alloc(32'h9010, 32'h40);
    store(32'h9048, 1'b1, "R2 end block from unaligned range");

    // Overlap: newest range decides (forward mode)
    idle(0);
    bidir = 1'b0;
    alloc(32'hA000, 32'd512);
    alloc(32'hA100, 32'd128);
    store(32'hA100, 1'b1, "R10 newest range hit");
    store(32'hA080, 1'b1, "R10 older range untouched");
    idle(1);

    // FIFO replacement: 64 two-block dummies evict all earlier entries
    for (int i = 0; i < 64; i++) alloc(32'h0010_0000 + 32'(i) * 32'h1000, 32'd128);
    store(32'h4040, 1'b0, "R9 earliest entries evicted");
    store(32'h0010_0000, 1'b1, "R9 oldest dummy present");
    alloc(32'h0020_0000, 32'd128);
    store(32'h0010_0040, 1'b0, "R9 oldest dummy replaced");
    store(32'h0010_1000, 1'b1, "R9 next dummy kept");
    store(32'h0020_0040, 1'b1, "R9 new entry present");
    idle(4);
    check(exp_q.size() == 0, "R3 all results arrived", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule